// File: doc/BRIEF.md
# Transmit Frame Assembler

The block gathers a transmit frame that a host writes as a sequence of 32-bit words. It holds the frame in an internal word buffer and then sends it out as a byte stream. The first word of a frame is a header. Its low half gives the payload length without the 14-byte header. Its high half carries the first two bytes of the frame. The length, together with the CRC-insert control input, sets how many bytes the host must supply. When enough bytes have arrived, the frame leaves as a byte stream with start and last flags. Short frames can optionally be padded with zeros to the 60-byte minimum.

A length above the allowed maximum causes a transmit-error pulse. The assembler then sits in an error state and drops all writes until the host acknowledges the error. Either that acknowledge or a separate clear pulse abandons a partly collected frame. While a finished frame is streaming out, the host write port deasserts ready, so writes wait rather than being lost.

Top module: `tx_frame_asm`

## Requirements
- R1: After a synchronous reset, `wr_ready` is 1 and `out_valid`, `irq_tx_empty` and `irq_tx_err` are 0.
- R2: In idle, an accepted write is a header word. Bits 15:0 are the payload length. Frame byte 0 is bits 23:16 and frame byte 1 is bits 31:24.
- R3: Each later word of the frame adds four bytes in little-endian order: bits 7:0 first, bits 31:24 last.
- R4: The number of bytes the host must supply is length+14, plus 4 more when `ctl_crc_ins` is 0. The frame completes on the write that brings the buffered count to that number or beyond. The emitted length is always length+14, so the four trailing bytes are dropped when `ctl_crc_ins` is 0.
- R5: When `ctl_pad_en` is 1 and length+14 is below 60, the frame goes out as 60 bytes and every byte from position length+14 onward is zero. Otherwise padding has no effect.
- R6: A header length above MAX_LEN (2032) produces a one-cycle `irq_tx_err` pulse. Until `err_ack` or `asm_clear` arrives, writes are accepted and discarded, and no frame is produced.
- R7: A pulse on `err_ack` or on `asm_clear` while collecting or in error returns the block to idle and discards the partial frame. The next accepted write is a header again.
- R8: An emitted frame goes out as consecutive `out_valid` cycles. `out_sop` is set on the first byte only, and `out_last` on the final byte only. `irq_tx_empty` pulses together with `out_last`.
- R9: `wr_ready` goes low right after the write that completes a frame and stays low while that frame is read out. A write held during that time is accepted later unchanged.
- R10: `ctl_crc_ins` and `ctl_pad_en` are sampled with the header word. Changing them later in the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write request |
| wr_data | input | 32 | Host write word |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| ctl_pad_en | input | 1 | Pad short frames to 60 bytes |
| ctl_crc_ins | input | 1 | CRC is inserted downstream; no trailing 4 bytes are supplied |
| err_ack | input | 1 | Transmit-error acknowledge pulse |
| asm_clear | input | 1 | Assembly clear pulse |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of frame |
| out_last | output | 1 | Final byte of frame |
| irq_tx_empty | output | 1 | Frame-sent interrupt pulse |
| irq_tx_err | output | 1 | Length-error interrupt pulse |

## Verification
The hardest case to reach is a host write that arrives while the previous frame is still streaming. The stimulus builds two frames in advance. It completes the first one and at once raises the second frame's header with valid high. That header is then held for the whole stream, and both frames are compared byte by byte. The bench also reaches the padding boundary at payload lengths 45 and 46, and the maximum legal length of 2032. It covers the error state, where the block keeps accepting words but must not emit them, and the clear and acknowledge pulses issued mid-frame.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_SEND, ST_ERR} tfa_state_e;
  localparam int HDR_BYTES = 14;
  localparam int FCS_BYTES = 4;
  localparam int MIN_FRAME = 60;
endpackage

// File: rtl/tfa_buf.sv
module tfa_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 513,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tfa_ctrl.sv
module tfa_ctrl
  import tfa_pkg::*;
#(
  parameter int MAX_LEN = 2032,
  parameter int AW      = 10,
  parameter int CW      = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [15:0]   hdr_len,
  output logic          wr_ready,
  input  logic          ctl_pad,
  input  logic          ctl_crc,
  input  logic          abort,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_lane,
  output logic          rd_zero,
  output logic          rd_first,
  output logic          rd_last,
  output logic          ev_err
);
  localparam logic [15:0] MAX_L = 16'(MAX_LEN);

  tfa_state_e    state_q;
  logic [CW-1:0] bcnt_q, exp_q, base_q, olen_q, rd_b_q;
  logic [AW-1:0] wcnt_q;

  logic          acc, len_bad;
  logic [CW-1:0] base_n, exp_n, olen_n, bsum, rd_pos;

  assign wr_ready = (state_q != ST_SEND);
  assign acc      = wr_valid && wr_ready;
  assign len_bad  = hdr_len > MAX_L;

  // header-time sizing: emitted length never includes the trailing 4 bytes
  assign base_n = CW'(hdr_len) + CW'(HDR_BYTES);
  assign exp_n  = base_n + (ctl_crc ? CW'(0) : CW'(FCS_BYTES));
  assign olen_n = (ctl_pad && (base_n < CW'(MIN_FRAME))) ? CW'(MIN_FRAME) : base_n;
  assign bsum   = bcnt_q + CW'(4);

  assign mem_we    = acc && (state_q == ST_IDLE || state_q == ST_COLLECT);
  assign mem_waddr = (state_q == ST_IDLE) ? '0 : wcnt_q;
  assign ev_err    = acc && (state_q == ST_IDLE) && !abort && len_bad;

  // byte b of the frame sits at offset b+2 of the word stream (header fills lanes 2,3)
  assign rd_pos   = rd_b_q + CW'(2);
  assign rd_en    = (state_q == ST_SEND);
  assign rd_addr  = AW'(rd_pos >> 2);
  assign rd_lane  = rd_pos[1:0];
  assign rd_zero  = (rd_b_q >= base_q);
  assign rd_first = (rd_b_q == '0);
  assign rd_last  = (rd_b_q == olen_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      exp_q   <= '0;
      base_q  <= '0;
      olen_q  <= '0;
      rd_b_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc && !abort) begin
            if (len_bad) begin
              state_q <= ST_ERR;
            end else begin
              exp_q   <= exp_n;
              base_q  <= base_n;
              olen_q  <= olen_n;
              bcnt_q  <= CW'(2);
              wcnt_q  <= AW'(1);
              state_q <= ST_COLLECT;
            end
          end
        end
        ST_COLLECT: begin
          if (abort) begin
            state_q <= ST_IDLE;
          end else if (acc) begin
            bcnt_q <= bsum;
            wcnt_q <= wcnt_q + AW'(1);
            if (bsum >= exp_q) begin
              rd_b_q  <= '0;
              state_q <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          rd_b_q <= rd_b_q + CW'(1);
          if (rd_last) state_q <= ST_IDLE;
        end
        ST_ERR: begin
          if (abort) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tfa_emit.sv
module tfa_emit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [1:0]    rd_lane,
  input  logic          rd_zero,
  input  logic          rd_first,
  input  logic          rd_last,
  input  logic          ev_err,
  input  logic [DW-1:0] mem_q,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_last,
  output logic          irq_tx_empty,
  output logic          irq_tx_err
);
  logic       s_v, s_zero, s_first, s_last;
  logic [1:0] s_lane;

  // stage 1 aligns the byte attributes with the buffer read
  always_ff @(posedge clk) begin
    if (rst) begin
      s_v     <= 1'b0;
      s_zero  <= 1'b0;
      s_first <= 1'b0;
      s_last  <= 1'b0;
      s_lane  <= '0;
    end else begin
      s_v     <= rd_en;
      s_zero  <= rd_zero;
      s_first <= rd_en && rd_first;
      s_last  <= rd_en && rd_last;
      s_lane  <= rd_lane;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sop      <= 1'b0;
      out_last     <= 1'b0;
      irq_tx_empty <= 1'b0;
      irq_tx_err   <= 1'b0;
    end else begin
      out_valid    <= s_v;
      out_data     <= (s_v && !s_zero) ? mem_q[8*s_lane +: 8] : 8'h00;
      out_sop      <= s_first;
      out_last     <= s_last;
      irq_tx_empty <= s_last;
      irq_tx_err   <= ev_err;
    end
  end
endmodule

// File: rtl/tx_frame_asm.sv
module tx_frame_asm
  import tfa_pkg::*;
#(
  parameter int MAX_LEN = 2032
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        wr_ready,
  input  logic        ctl_pad_en,
  input  logic        ctl_crc_ins,
  input  logic        err_ack,
  input  logic        asm_clear,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_last,
  output logic        irq_tx_empty,
  output logic        irq_tx_err
);
  localparam int DW        = 32;
  localparam int BYTE_MAX  = MAX_LEN + HDR_BYTES + FCS_BYTES + 8;
  localparam int CW        = $clog2(BYTE_MAX + 1);
  localparam int DEPTH_RAW = (MAX_LEN + HDR_BYTES + FCS_BYTES + 2 + 3) / 4;
  localparam int DEPTH     = (DEPTH_RAW < 16) ? 16 : DEPTH_RAW;
  localparam int AW        = $clog2(DEPTH);

  logic          mem_we, rd_en, rd_zero, rd_first, rd_last, ev_err;
  logic [AW-1:0] mem_waddr, rd_addr;
  logic [1:0]    rd_lane;
  logic [DW-1:0] mem_q;

  tfa_ctrl #(.MAX_LEN(MAX_LEN), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .hdr_len(wr_data[15:0]),
    .wr_ready(wr_ready), .ctl_pad(ctl_pad_en), .ctl_crc(ctl_crc_ins),
    .abort(err_ack | asm_clear), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_lane(rd_lane), .rd_zero(rd_zero),
    .rd_first(rd_first), .rd_last(rd_last), .ev_err(ev_err)
  );

  tfa_buf #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(mem_q)
  );

  tfa_emit #(.DW(DW)) u_emit (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_lane(rd_lane), .rd_zero(rd_zero),
    .rd_first(rd_first), .rd_last(rd_last), .ev_err(ev_err), .mem_q(mem_q),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_last(out_last), .irq_tx_empty(irq_tx_empty), .irq_tx_err(irq_tx_err)
  );
endmodule

// File: rtl/tx_frame_asm_chk.sv
module tx_frame_asm_chk (
  input logic clk,
  input logic rst,
  input logic wr_valid,
  input logic wr_ready,
  input logic out_valid,
  input logic out_sop,
  input logic out_last,
  input logic irq_tx_empty,
  input logic irq_tx_err
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (wr_ready && !out_valid && !irq_tx_empty && !irq_tx_err));

  a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_sop && !out_last && !irq_tx_empty));

  a_r8_stream_contiguous: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  a_r8_sop_not_last: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> !out_last);

  a_r9_ready_falls_on_write: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_ready) |-> $past(wr_valid));

  a_r9_held_while_streaming: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> !$past(wr_ready));

  a_r6_err_not_at_sop: assert property (@(posedge clk) disable iff (rst)
    irq_tx_err |-> !out_sop);
endmodule

bind tx_frame_asm tx_frame_asm_chk u_chk (.*);

// File: tb/tx_frame_asm_tb.sv
module tx_frame_asm_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic        ctl_pad_en = 1'b0, ctl_crc_ins = 1'b0, err_ack = 1'b0, asm_clear = 1'b0;
  logic        out_valid, out_sop, out_last, irq_tx_empty, irq_tx_err;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  tx_frame_asm u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int nframes = 0, empty_cnt = 0, err_cnt = 0, proto_err = 0;
  int cur_n = 0, got_len = 0, exp_frames = 0;
  logic [7:0]  got   [2100];
  logic [7:0]  exp_b [2][2100];
  logic [31:0] wrd   [2][600];
  int          nwords [2];
  int          olen   [2];
  logic        s_crc [2];
  logic        s_pad [2];

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_tx_empty) empty_cnt++;
      if (irq_tx_err) err_cnt++;
      if (out_valid) begin
        if (out_sop != (cur_n == 0)) proto_err++;
        if (irq_tx_empty != out_last) proto_err++;
        if (cur_n < 2100) got[cur_n] = out_data;
        cur_n++;
        if (out_last) begin
          got_len = cur_n;
          cur_n = 0;
          nframes++;
        end
      end else if (out_sop || out_last) proto_err++;
    end
  end

  task automatic build(input int slot, input int len, input bit crc, input bit pad);
    int ec, base, nw;
    logic [31:0] w;
    ec   = len + 14 + (crc ? 0 : 4);
    base = len + 14;
    olen[slot] = (pad && base < 60) ? 60 : base;
    nw   = (ec - 2 + 3) / 4;
    nwords[slot] = nw + 1;
    s_crc[slot] = crc;
    s_pad[slot] = pad;
    w = {$urandom_range(65535, 0)} << 16;
    w[15:0] = len[15:0];
    wrd[slot][0] = w;
    exp_b[slot][0] = w[23:16];
    exp_b[slot][1] = w[31:24];
    for (int i = 1; i <= nw; i++) begin
      w = $urandom;
      wrd[slot][i] = w;
      for (int k = 0; k < 4; k++) exp_b[slot][2 + 4*(i-1) + k] = w[8*k +: 8];
    end
    for (int b = base; b < olen[slot]; b++) exp_b[slot][b] = 8'h00;
  endtask

  // holds wr_valid until the word is taken at a clock edge
  task automatic put_word(input logic [31:0] w);
    bit ok;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    forever begin
      ok = wr_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    #1;
  endtask

  task automatic drive(input int slot);
    ctl_crc_ins = s_crc[slot];
    ctl_pad_en  = s_pad[slot];
    put_word(wrd[slot][0]);
    // R10: controls change after the header and must be ignored
    ctl_crc_ins = $urandom_range(1, 0);
    ctl_pad_en  = $urandom_range(1, 0);
    for (int i = 1; i < nwords[slot]; i++) put_word(wrd[slot][i]);
    wr_valid = 1'b0;
  endtask

  task automatic verify(input int slot, input string tag);
    int t = 0;
    int bad = -1;
    exp_frames++;
    while (nframes < exp_frames && t < 6000) begin
      @(negedge clk);
      t++;
    end
    chk(nframes == exp_frames, {tag, " R8 frame count"}, nframes, exp_frames);
    chk(got_len == olen[slot], {tag, " R4 R5 R10 emitted length"}, got_len, olen[slot]);
    for (int b = 0; b < olen[slot] && b < 2100; b++)
      if (bad < 0 && got[b] !== exp_b[slot][b]) bad = b;
    if (bad >= 0)
      chk(1'b0, {tag, " R2 R3 R5 byte mismatch"}, int'(got[bad]), int'(exp_b[slot][bad]));
    else
      chk(1'b1, {tag, " R2 R3 R5 bytes"}, 0, 0);
    chk(proto_err == 0 && empty_cnt == nframes, {tag, " R8 flags/irq_tx_empty"}, empty_cnt, nframes);
  endtask

  task automatic pulse_ack();
    @(negedge clk); err_ack = 1'b1;
    @(negedge clk); err_ack = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); asm_clear = 1'b1;
    @(negedge clk); asm_clear = 1'b0;
  endtask

  task automatic run(input int len, input bit crc, input bit pad, input string tag);
    build(0, len, crc, pad);
    drive(0);
    verify(0, tag);
  endtask

  initial begin
    int e0, f0;
    void'($urandom(32'h1f2e3d4c));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(wr_ready === 1'b1, "R1 reset wr_ready", wr_ready, 1);
    chk(out_valid === 1'b0 && irq_tx_empty === 1'b0 && irq_tx_err === 1'b0,
        "R1 reset outputs idle", out_valid, 0);

    run(0, 1'b1, 1'b0, "len0 crc");
    run(0, 1'b0, 1'b0, "len0 nocrc R4");
    run(10, 1'b1, 1'b1, "pad short R5");
    run(45, 1'b1, 1'b1, "pad 59 R5");
    run(46, 1'b0, 1'b1, "pad 60 exact R5");
    run(100, 1'b0, 1'b1, "pad no effect R5");

    // R9: ready drops right after the completing write
    build(0, 20, 1'b1, 1'b0);
    drive(0);
    chk(wr_ready === 1'b0, "R9 ready low after completion", wr_ready, 0);
    verify(0, "R9 single");

    // R9: next header held during streaming
    build(0, 200, 1'b0, 1'b0);
    build(1, 7, 1'b1, 1'b1);
    drive(0);
    fork
      drive(1);
      verify(0, "R9 back-to-back first");
    join
    verify(1, "R9 back-to-back second");

    // R6: oversize length, then discarded words, then acknowledge
    e0 = err_cnt; f0 = nframes;
    ctl_crc_ins = 1'b1;
    put_word({16'h1234, 16'd2033});
    wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(err_cnt == e0 + 1, "R6 irq_tx_err pulse", err_cnt, e0 + 1);
    for (int i = 0; i < 6; i++) put_word($urandom);
    wr_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(nframes == f0, "R6 no frame from error state", nframes, f0);
    chk(wr_ready === 1'b1, "R6 words accepted in error", wr_ready, 1);
    pulse_ack();
    run(30, 1'b1, 1'b0, "R6 after err_ack");

    e0 = err_cnt;
    put_word({16'h0000, 16'hffff});
    wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(err_cnt == e0 + 1, "R6 irq_tx_err max field", err_cnt, e0 + 1);
    pulse_clear();
    run(3, 1'b0, 1'b1, "R7 clear leaves error");

    // R7: partial frames discarded
    f0 = nframes;
    build(0, 40, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      ctl_crc_ins = s_crc[0];
      put_word(wrd[0][i]);
    end
    wr_valid = 1'b0;
    pulse_clear();
    repeat (20) @(negedge clk);
    chk(nframes == f0, "R7 clear discards partial", nframes, f0);
    run(12, 1'b1, 1'b0, "R7 after clear");
    build(0, 64, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) put_word(wrd[0][i]);
    wr_valid = 1'b0;
    pulse_ack();
    run(1, 1'b0, 1'b0, "R7 after err_ack mid-frame");

    run(2032, 1'b0, 1'b1, "max length R4");
    run(2032, 1'b1, 1'b0, "max length crc R4");

    for (int n = 0; n < 40; n++) begin
      int len;
      len = ($urandom_range(7, 0) == 0) ? $urandom_range(2032, 0) : $urandom_range(120, 0);
      run(len, $urandom_range(1, 0), $urandom_range(1, 0), "random R2 R3 R4 R5");
    end

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule